// File: doc/BRIEF.md
# Iterative Signed Divide and Modulo Unit

This block divides one integer operand by another, one quotient bit per clock, and produces a quotient and a remainder. A mode input selects how the results leave the block. In legacy mode both results are written together to a high/low result pair: quotient to low and remainder to high. In that mode a separate flag can make the operation unsigned. In the newer mode a sub-opcode picks a single result, quotient or remainder, and writes it to a caller-named destination register index.

The two arithmetic corner cases are handled without any trap. A most-negative dividend over minus one wraps the quotient back to the most-negative value and gives a zero remainder. A zero divisor completes normally but suppresses every write. A sub-opcode the newer mode does not know is reported on a flag, and nothing is written.

A caller pulses the start input while the unit is idle. It then waits for the one-cycle done pulse, on which the write enables and data are valid.

Top module: `divmod_unit`

## Requirements
- R1: In legacy mode with signed operands, done is accompanied by hi_we_o and lo_we_o. lo_o carries the quotient truncated toward zero, and hi_o carries the remainder, which takes the dividend's sign.
- R2: A most-negative dividend divided by -1 yields the most-negative value as quotient and 0 as remainder, in both modes.
- R3: A zero divisor still completes with done_o. It raises no write enable and leaves unimpl_o low, and hi_o, lo_o and rd_data_o keep their previous values.
- R4: In the newer mode (legacy_i = 0), sub-opcode 2 asserts rd_we_o with rd_addr_o equal to dest_i and rd_data_o equal to the signed quotient. hi_we_o and lo_we_o stay low.
- R5: In the newer mode, sub-opcode 3 asserts rd_we_o with rd_data_o equal to the signed remainder.
- R6: In the newer mode, any sub-opcode other than 2 or 3 raises unimpl_o together with done_o and writes nothing.
- R7: In legacy mode with unsigned_i = 1, operands are unsigned: lo_o gets the unsigned quotient and hi_o the unsigned remainder. A zero divisor writes nothing.
- R8: In the newer mode unsigned_i has no effect; operands are always signed.
- R9: The following timing holds:
  - done_o pulses for exactly one cycle, W+1 clock edges after the edge that accepted start_i.
  - busy_o is high in between.
  - A start_i pulse while busy is ignored.
- R10: After reset, busy_o, done_o, unimpl_o and all write enables are low, and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (accepted only when idle) |
| legacy_i | input | 1 | 1 = high/low pair writeback, 0 = single destination writeback |
| unsigned_i | input | 1 | Unsigned operands (legacy mode only) |
| subop_i | input | 5 | Newer-mode selector: 2 quotient, 3 remainder |
| dest_i | input | AW | Destination register index for the newer mode |
| dividend_i | input | W | Dividend |
| divisor_i | input | W | Divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| unimpl_o | output | 1 | Unknown sub-opcode, valid with done_o |
| hi_we_o | output | 1 | High result write enable |
| hi_o | output | W | High result (remainder) |
| lo_we_o | output | 1 | Low result write enable |
| lo_o | output | W | Low result (quotient) |
| rd_we_o | output | 1 | Destination write enable |
| rd_addr_o | output | AW | Destination register index |
| rd_data_o | output | W | Destination data (quotient or remainder) |

## Verification
The assertions check the following on every cycle:
- done_o is a single-cycle pulse, and it arrives after exactly W iteration steps.
- Write enables never appear outside done_o.
- The two writeback styles are never active together.
- An unknown sub-opcode or a zero divisor never produces a write.
- The partial remainder stays below the divisor.

The numeric values need the bench's scenarios. These cover truncation direction and remainder sign across random operands, the most-negative over minus one wrap, and unsigned interpretation. They also cover the rule that a zero divisor leaves the previous register contents untouched, and that a start pulse arriving mid-operation does not disturb the result.

// File: rtl/dvm_pkg.sv
package dvm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STEP = 2'd1,
    ST_FIX  = 2'd2
  } dvm_state_e;

  localparam int unsigned         SUBOP_W   = 5;
  localparam logic [SUBOP_W-1:0]  SUBOP_QUO = 5'd2;
  localparam logic [SUBOP_W-1:0]  SUBOP_REM = 5'd3;
endpackage

// File: rtl/dvm_ctrl.sv
module dvm_ctrl
  import dvm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic fin_o,
  output logic busy_o
);
  localparam int CW = $clog2(W + 1);

  dvm_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load_o  = 1'b0;
    step_o  = 1'b0;
    fin_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          state_d = ST_STEP;
          cnt_d   = CW'(W - 1);
        end
      end
      ST_STEP: begin
        step_o = 1'b1;
        if (cnt_q == '0) state_d = ST_FIX;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_FIX: begin
        fin_o   = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);

  // Step counter kept for checking only: iterations since the last load.
  logic [CW:0] chk_steps_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      chk_steps_q <= '0;
    else if (load_o) chk_steps_q <= '0;
    else if (step_o) chk_steps_q <= chk_steps_q + 1'b1;
  end

  a_r9_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
  a_r9_fix_after_w_steps: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |-> (chk_steps_q == (CW+1)'(W)));
  a_r9_no_reload_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !load_o);
endmodule

// File: rtl/dvm_core.sv
module dvm_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] a_mag_i,
  input  logic [W-1:0] b_mag_i,
  output logic [W-1:0] quo_mag_o,
  output logic [W-1:0] rem_mag_o
);
  logic [W:0]   part_q, part_d;
  logic [W-1:0] quo_q, quo_d;
  logic [W-1:0] dvs_q, dvs_d;
  logic [W:0]   shifted;
  logic [W:0]   trial;

  always_comb begin
    shifted = {part_q[W-1:0], quo_q[W-1]};
    trial   = shifted - {1'b0, dvs_q};
    part_d  = part_q;
    quo_d   = quo_q;
    dvs_d   = dvs_q;
    if (load_i) begin
      part_d = '0;
      quo_d  = a_mag_i;
      dvs_d  = b_mag_i;
    end else if (step_i) begin
      if (!trial[W]) begin
        part_d = trial;
        quo_d  = {quo_q[W-2:0], 1'b1};
      end else begin
        part_d = shifted;
        quo_d  = {quo_q[W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
    end else if (load_i || step_i) begin
      part_q <= part_d;
      quo_q  <= quo_d;
      dvs_q  <= dvs_d;
    end
  end

  assign quo_mag_o = quo_q;
  assign rem_mag_o = part_q[W-1:0];

  a_r1_partial_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (dvs_q != '0) |-> (part_q < {1'b0, dvs_q}));
endmodule

// File: rtl/dvm_wb.sv
module dvm_wb
  import dvm_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               fin_i,
  input  logic [W-1:0]       dividend_i,
  input  logic [W-1:0]       divisor_i,
  input  logic               legacy_i,
  input  logic               unsigned_i,
  input  logic [SUBOP_W-1:0] subop_i,
  input  logic [AW-1:0]      dest_i,
  input  logic [W-1:0]       quo_mag_i,
  input  logic [W-1:0]       rem_mag_i,
  output logic [W-1:0]       a_mag_o,
  output logic [W-1:0]       b_mag_o,
  output logic               done_o,
  output logic               unimpl_o,
  output logic               hi_we_o,
  output logic [W-1:0]       hi_o,
  output logic               lo_we_o,
  output logic [W-1:0]       lo_o,
  output logic               rd_we_o,
  output logic [AW-1:0]      rd_addr_o,
  output logic [W-1:0]       rd_data_o
);
  logic signed_eff, a_neg, b_neg;

  always_comb begin
    signed_eff = legacy_i ? !unsigned_i : 1'b1;
    a_neg      = signed_eff && dividend_i[W-1];
    b_neg      = signed_eff && divisor_i[W-1];
    a_mag_o    = a_neg ? (~dividend_i + 1'b1) : dividend_i;
    b_mag_o    = b_neg ? (~divisor_i + 1'b1) : divisor_i;
  end

  // Operation context captured at load.
  logic               nq_q, nr_q, dz_q, leg_q;
  logic [SUBOP_W-1:0] sub_q;
  logic [AW-1:0]      dst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nq_q  <= 1'b0;
      nr_q  <= 1'b0;
      dz_q  <= 1'b0;
      leg_q <= 1'b0;
      sub_q <= '0;
      dst_q <= '0;
    end else if (load_i) begin
      nq_q  <= a_neg ^ b_neg;
      nr_q  <= a_neg;
      dz_q  <= (divisor_i == '0);
      leg_q <= legacy_i;
      sub_q <= subop_i;
      dst_q <= dest_i;
    end
  end

  logic [W-1:0] quo_fix, rem_fix;
  logic         bad_sub, pair_en, dst_en, is_rem;
  logic         done_d, unimpl_d;

  always_comb begin
    quo_fix  = nq_q ? (~quo_mag_i + 1'b1) : quo_mag_i;
    rem_fix  = nr_q ? (~rem_mag_i + 1'b1) : rem_mag_i;
    is_rem   = (sub_q == SUBOP_REM);
    bad_sub  = !leg_q && (sub_q != SUBOP_QUO) && !is_rem;
    pair_en  = fin_i && leg_q && !dz_q;
    dst_en   = fin_i && !leg_q && !dz_q && !bad_sub;
    done_d   = fin_i;
    unimpl_d = fin_i && bad_sub;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o   <= 1'b0;
      unimpl_o <= 1'b0;
      hi_we_o  <= 1'b0;
      lo_we_o  <= 1'b0;
      rd_we_o  <= 1'b0;
    end else begin
      done_o   <= done_d;
      unimpl_o <= unimpl_d;
      hi_we_o  <= pair_en;
      lo_we_o  <= pair_en;
      rd_we_o  <= dst_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_o <= '0;
      lo_o <= '0;
    end else if (pair_en) begin
      hi_o <= rem_fix;
      lo_o <= quo_fix;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr_o <= '0;
      rd_data_o <= '0;
    end else if (dst_en) begin
      rd_addr_o <= dst_q;
      rd_data_o <= is_rem ? rem_fix : quo_fix;
    end
  end

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r3_zero_div_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_i && dz_q) |=> (done_o && !hi_we_o && !lo_we_o && !rd_we_o));
  a_r4_one_style: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we_o |-> (!hi_we_o && !lo_we_o));
  a_r6_unimpl_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    unimpl_o |-> (done_o && !rd_we_o && !hi_we_o));
  a_r1_we_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we_o || lo_we_o || rd_we_o) |-> done_o);
endmodule

// File: rtl/divmod_unit.sv
module divmod_unit
  import dvm_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               legacy_i,
  input  logic               unsigned_i,
  input  logic [SUBOP_W-1:0] subop_i,
  input  logic [AW-1:0]      dest_i,
  input  logic [W-1:0]       dividend_i,
  input  logic [W-1:0]       divisor_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               unimpl_o,
  output logic               hi_we_o,
  output logic [W-1:0]       hi_o,
  output logic               lo_we_o,
  output logic [W-1:0]       lo_o,
  output logic               rd_we_o,
  output logic [AW-1:0]      rd_addr_o,
  output logic [W-1:0]       rd_data_o
);
  logic         load, step, fin;
  logic [W-1:0] a_mag, b_mag, quo_mag, rem_mag;

  dvm_ctrl #(.W(W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .fin_o  (fin),
    .busy_o (busy_o)
  );

  dvm_core #(.W(W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .step_i   (step),
    .a_mag_i  (a_mag),
    .b_mag_i  (b_mag),
    .quo_mag_o(quo_mag),
    .rem_mag_o(rem_mag)
  );

  dvm_wb #(.W(W), .AW(AW)) u_wb (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .fin_i     (fin),
    .dividend_i(dividend_i),
    .divisor_i (divisor_i),
    .legacy_i  (legacy_i),
    .unsigned_i(unsigned_i),
    .subop_i   (subop_i),
    .dest_i    (dest_i),
    .quo_mag_i (quo_mag),
    .rem_mag_i (rem_mag),
    .a_mag_o   (a_mag),
    .b_mag_o   (b_mag),
    .done_o    (done_o),
    .unimpl_o  (unimpl_o),
    .hi_we_o   (hi_we_o),
    .hi_o      (hi_o),
    .lo_we_o   (lo_we_o),
    .lo_o      (lo_o),
    .rd_we_o   (rd_we_o),
    .rd_addr_o (rd_addr_o),
    .rd_data_o (rd_data_o)
  );

  a_r9_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

// File: tb/sim_divmod_unit.sv
`timescale 1ns/1ps
module sim_divmod_unit;
  localparam int W  = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i, legacy_i, unsigned_i;
  logic [4:0]    subop_i;
  logic [AW-1:0] dest_i;
  logic [W-1:0]  dividend_i, divisor_i;
  logic          busy_o, done_o, unimpl_o, hi_we_o, lo_we_o, rd_we_o;
  logic [W-1:0]  hi_o, lo_o, rd_data_o;
  logic [AW-1:0] rd_addr_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0]  m_hi = '0, m_lo = '0, m_rd = '0;
  logic [AW-1:0] m_addr = '0;

  always #10 clk = ~clk;

  divmod_unit #(.W(W), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .legacy_i(legacy_i),
    .unsigned_i(unsigned_i), .subop_i(subop_i), .dest_i(dest_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i), .busy_o(busy_o),
    .done_o(done_o), .unimpl_o(unimpl_o), .hi_we_o(hi_we_o), .hi_o(hi_o),
    .lo_we_o(lo_we_o), .lo_o(lo_o), .rd_we_o(rd_we_o), .rd_addr_o(rd_addr_o),
    .rd_data_o(rd_data_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void ref_div(input logic [W-1:0] a, input logic [W-1:0] b, input bit uns,
                                  output logic [W-1:0] q, output logic [W-1:0] r);
    longint sa, sb;
    if (uns) begin
      q = a / b;
      r = a % b;
    end else begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      q = W'(sa / sb);
      r = W'(sa % sb);
    end
  endfunction

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit leg,
                        input bit uns, input logic [4:0] sub, input logic [AW-1:0] dst,
                        input bit poke, input string tag);
    int cyc;
    logic [W-1:0] q, r;
    bit uns_eff;
    @(negedge clk);
    start_i = 1'b1; dividend_i = a; divisor_i = b; legacy_i = leg;
    unsigned_i = uns; subop_i = sub; dest_i = dst;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b1, {tag, " R9 busy"}, W'(busy_o), 1);
    cyc = 0;
    while (!done_o && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 3) begin
        start_i = 1'b1; dividend_i = 32'h1234_5678; divisor_i = 32'd7;
        legacy_i = ~leg; subop_i = 5'd3; dest_i = ~dst;
      end else begin
        start_i = 1'b0;
      end
    end
    chk(cyc == W + 1, {tag, " R9 latency"}, W'(cyc), W'(W + 1));
    uns_eff = leg && uns;
    if (b != '0) ref_div(a, b, uns_eff, q, r);
    else begin q = '0; r = '0; end
    if (leg) begin
      if (b != '0) begin m_lo = q; m_hi = r; end
      chk(hi_we_o === (b != '0) && lo_we_o === (b != '0) && rd_we_o === 1'b0,
          {tag, " R1 R3 R7 pair we"}, {29'd0, hi_we_o, lo_we_o, rd_we_o},
          {29'd0, b != '0, b != '0, 1'b0});
    end else if (sub != 5'd2 && sub != 5'd3) begin
      chk(unimpl_o === 1'b1 && rd_we_o === 1'b0 && hi_we_o === 1'b0, {tag, " R6 unimpl"},
          {30'd0, unimpl_o, rd_we_o}, 32'd2);
    end else begin
      if (b != '0) begin m_rd = (sub == 5'd2) ? q : r; m_addr = dst; end
      chk(rd_we_o === (b != '0) && hi_we_o === 1'b0 && unimpl_o === 1'b0,
          {tag, " R3 R4 R5 R8 rd we"}, {30'd0, rd_we_o, unimpl_o}, {30'd0, b != '0, 1'b0});
    end
    chk(lo_o === m_lo, {tag, " R1 R2 R7 lo"}, lo_o, m_lo);
    chk(hi_o === m_hi, {tag, " R1 R2 R7 hi"}, hi_o, m_hi);
    chk(rd_data_o === m_rd, {tag, " R4 R5 R8 rd data"}, rd_data_o, m_rd);
    chk(rd_addr_o === m_addr, {tag, " R4 rd addr"}, W'(rd_addr_o), W'(m_addr));
    @(negedge clk);
    chk(done_o === 1'b0 && busy_o === 1'b0, {tag, " R9 single done"}, {30'd0, done_o, busy_o}, 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    $display("FAIL watchdog expired");
    n_chk++;
    n_bad++;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [W-1:0] a, b;
    logic [4:0] sub;
    bit leg, uns;
    void'($urandom(32'h0D1F_5EED));
    rst_n = 1'b0; start_i = 1'b0; legacy_i = 1'b0; unsigned_i = 1'b0;
    subop_i = '0; dest_i = '0; dividend_i = '0; divisor_i = '0;
    repeat (3) @(negedge clk);
    chk({busy_o, done_o, unimpl_o, hi_we_o, lo_we_o, rd_we_o} === 6'b0, "R10 flags", 0, 0);
    chk(hi_o === '0 && lo_o === '0 && rd_data_o === '0, "R10 data", lo_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // Directed corners
    run_op(32'd100, 32'd7, 1, 0, 0, 0, 0, "R1 pos");
    run_op(-32'sd100, 32'd7, 1, 0, 0, 0, 0, "R1 neg dividend");
    run_op(32'd100, -32'sd7, 1, 0, 0, 0, 0, "R1 neg divisor");
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1, 0, 0, 0, 0, "R2 legacy overflow");
    run_op(32'd55, 32'd0, 1, 0, 0, 0, 0, "R3 legacy zero");
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 0, 0, 5'd2, 5'd9, 0, "R2 new quo");
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 0, 0, 5'd3, 5'd10, 0, "R2 new rem");
    run_op(32'd77, 32'd0, 0, 0, 5'd2, 5'd4, 0, "R3 new zero");
    run_op(-32'sd17, 32'd5, 0, 0, 5'd3, 5'd31, 0, "R5 rem sign");
    run_op(32'd40, 32'd6, 0, 0, 5'd1, 5'd3, 0, "R6 bad sub");
    run_op(32'hFFFF_FFF0, 32'd3, 1, 1, 0, 0, 0, "R7 unsigned");
    run_op(32'hFFFF_FFF0, 32'd0, 1, 1, 0, 0, 0, "R7 unsigned zero");
    run_op(32'hFFFF_FFF0, 32'd3, 0, 1, 5'd2, 5'd6, 0, "R8 flag ignored");
    run_op(32'd1000, 32'd9, 0, 0, 5'd2, 5'd12, 1, "R9 start while busy");
    // Random mix
    for (int i = 0; i < 300; i++) begin
      a = $urandom;
      b = ($urandom_range(0, 3) == 0) ? W'($urandom_range(0, 20)) : $urandom;
      if ($urandom_range(0, 7) == 0) a = 32'h8000_0000;
      if ($urandom_range(0, 7) == 0) b = 32'hFFFF_FFFF;
      if ($urandom_range(0, 9) == 0) b = '0;
      leg = $urandom_range(0, 1);
      uns = $urandom_range(0, 1);
      case ($urandom_range(0, 4))
        0:       sub = 5'($urandom);
        1, 2:    sub = 5'd2;
        default: sub = 5'd3;
      endcase
      run_op(a, b, leg, uns, sub, 5'($urandom), 0, "random");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule